// File: doc/BRIEF.md
# Bus Clock Low Time-out Guard

This block guards the clock line of a two-wire serial bus against being held low for too long. It samples the line level, brings it into its own clock domain through a short synchronizer chain, and starts a countdown when it has reason to wait for the line. That happens when the controller is in master mode and the line falls, or when a start is requested while the line is already low. The countdown advances on a single-cycle base tick that the surrounding controller supplies. If the line is still low when the programmed number of ticks has run out, the block declares a bus error.

The block has a single 8-bit configuration byte. The top bit switches the guard on, and the seven lower bits give the count. The period is the count plus one, in base ticks. On a bus error the block does four things. It emits a one-cycle error pulse, switches its status code to the error value, raises an interrupt, and orders the clock and data drivers to let go of the bus. It then stays locked until the lock-clear input is applied. Reading the status does not clear the lock.

Top module: `scl_lowtime_guard`

## Requirements
- R1: The configuration byte resets to 00h, is written by `cfg_we` with `cfg_wdata`, and reads back unchanged on `cfg_rdata`. Bit 7 is the enable, and bits 6:0 are the count N.
- R2: With the guard enabled and `master_mode` high, a falling clock level seen after the synchronizer arms the countdown. If the line stays low, the error is declared on the (N+1)-th tick pulse after arming, and not on the N-th.
- R3: `err_pulse` is high for exactly one clock cycle per declared error.
- R4: With bit 7 of the configuration at 0, no error is ever declared, whatever the line does and however many ticks arrive.
- R5: While an error is latched, `irq` and `release_lines` are 1 and `status` is 78h. Otherwise `irq` and `release_lines` are 0 and `status` is F8h.
- R6: A one-cycle `start_req` while the synchronized line is low arms the same countdown even when `master_mode` is 0. The error then falls on the (N+1)-th tick.
- R7: A rising clock level before expiry cancels the countdown without an error. This includes the case where the rise is seen in the same cycle as the final tick. The next fall reloads the full count.
- R8: A latched error persists through line activity and further ticks until `lock_clr` is high for a cycle. One cycle after that, `irq` is 0 and `status` is F8h.
- R9: With `master_mode` at 0 and no start request, a falling line does not arm the countdown.
- R10: A `start_req` while the line is high does not arm the countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw clock-line level from the pad |
| tick | input | 1 | One-cycle base time unit pulse |
| master_mode | input | 1 | Controller is acting as bus master |
| start_req | input | 1 | Controller requests a start condition |
| lock_clr | input | 1 | Clears a latched bus error |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data |
| err_pulse | output | 1 | One-cycle bus error indication |
| status | output | 8 | Status code, 78h on error, F8h otherwise |
| irq | output | 1 | Interrupt request, held while error is latched |
| release_lines | output | 1 | Orders the clock and data drivers to release |

## Verification
The last tick of a countdown and the synchronized rising edge of the clock line can land in the same cycle. In that case the block must treat the line as released and declare no error. The bench arranges this by driving the line high and then placing the final tick in exactly the cycle in which the rise has crossed the two-stage synchronizer. It then checks that neither an interrupt nor the error status appears, and that later ticks with the line high stay quiet.

// File: rtl/sclg_pkg.sv
package sclg_pkg;
   localparam int unsigned SCLG_CFG_W   = 8;
   localparam logic [7:0]  SCLG_ST_ERR  = 8'h78;
   localparam logic [7:0]  SCLG_ST_IDLE = 8'hF8;
endpackage

// File: rtl/sclg_sync.sv
module sclg_sync #(
   parameter int unsigned STAGES    = 2,
   parameter logic        RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("sclg_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RESET_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/sclg_timer.sv
module sclg_timer #(
   parameter int unsigned CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [CNT_W-1:0] limit,
   input  logic             hold,
   input  logic             line_lvl,
   input  logic             master_mode,
   input  logic             start_req,
   input  logic             tick,
   output logic             expire
);
   logic             prev_lvl;
   logic             armed;
   logic [CNT_W-1:0] cnt;
   logic             fall_seen;
   logic             rise_seen;
   logic             arm_req;
   logic             at_zero;

   assign fall_seen = prev_lvl & ~line_lvl;
   assign rise_seen = ~prev_lvl & line_lvl;
   assign arm_req   = (master_mode & fall_seen) | (start_req & ~line_lvl & ~armed);
   assign at_zero   = (cnt == '0);
   assign expire    = armed & tick & at_zero & ~rise_seen & en & ~hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_lvl <= 1'b1;
      else        prev_lvl <= line_lvl;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (fall_seen | rise_seen | (arm_req & ~armed)) begin
         cnt <= limit;
      end else if (armed & tick & ~at_zero) begin
         cnt <= cnt - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
      end else if (~en | hold | rise_seen | expire) begin
         armed <= 1'b0;
      end else if (arm_req) begin
         armed <= 1'b1;
      end
   end
endmodule

// File: rtl/sclg_lock.sv
module sclg_lock (
   input  logic clk,
   input  logic rst_n,
   input  logic expire,
   input  logic lock_clr,
   output logic err_pulse,
   output logic locked
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_pulse <= 1'b0;
         locked    <= 1'b0;
      end else begin
         err_pulse <= expire & ~lock_clr;
         if (lock_clr)    locked <= 1'b0;
         else if (expire) locked <= 1'b1;
      end
   end
endmodule

// File: rtl/scl_lowtime_guard.sv
module scl_lowtime_guard
   import sclg_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned CFG_W       = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_in,
   input  logic             tick,
   input  logic             master_mode,
   input  logic             start_req,
   input  logic             lock_clr,
   input  logic             cfg_we,
   input  logic [CFG_W-1:0] cfg_wdata,
   output logic [CFG_W-1:0] cfg_rdata,
   output logic             err_pulse,
   output logic [7:0]       status,
   output logic             irq,
   output logic             release_lines
);
   localparam int unsigned CNT_W  = CFG_W - 1;
   localparam int unsigned EN_BIT = CFG_W - 1;

   generate
      if (CFG_W != SCLG_CFG_W) begin : g_bad_w
         $error("configuration width must match the package width");
      end
   endgenerate

   logic [CFG_W-1:0] cfg_q;
   logic             line_lvl;
   logic             expire;
   logic             locked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q <= '0;
      else if (cfg_we) cfg_q <= cfg_wdata;
   end

   sclg_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (scl_in),
      .q     (line_lvl)
   );

   sclg_timer #(.CNT_W(CNT_W)) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .en          (cfg_q[EN_BIT]),
      .limit       (cfg_q[CNT_W-1:0]),
      .hold        (locked | lock_clr),
      .line_lvl    (line_lvl),
      .master_mode (master_mode),
      .start_req   (start_req),
      .tick        (tick),
      .expire      (expire)
   );

   sclg_lock u_lock (
      .clk       (clk),
      .rst_n     (rst_n),
      .expire    (expire),
      .lock_clr  (lock_clr),
      .err_pulse (err_pulse),
      .locked    (locked)
   );

   assign cfg_rdata     = cfg_q;
   assign irq           = locked;
   assign release_lines = locked;
   assign status        = locked ? SCLG_ST_ERR : SCLG_ST_IDLE;
endmodule

// File: rtl/sclg_guard_chk.sv
module sclg_guard_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       lock_clr,
   input logic [7:0] cfg_rdata,
   input logic       err_pulse,
   input logic [7:0] status,
   input logic       irq,
   input logic       release_lines
);
   a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |=> !err_pulse);

   a_r5_error_outputs: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |-> (irq && release_lines && status == 8'h78));

   a_r5_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
      !irq |-> (status == 8'hF8 && !release_lines));

   a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !lock_clr) |=> irq);

   a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      lock_clr |=> !irq);

   a_r4_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cfg_rdata[7]) |-> !err_pulse);
endmodule

bind scl_lowtime_guard sclg_guard_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .lock_clr      (lock_clr),
   .cfg_rdata     (cfg_rdata),
   .err_pulse     (err_pulse),
   .status        (status),
   .irq           (irq),
   .release_lines (release_lines)
);

// File: tb/scl_lowtime_guard_tb.sv
module scl_lowtime_guard_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_in = 1'b1;
   logic       tick = 1'b0;
   logic       master_mode = 1'b1;
   logic       start_req = 1'b0;
   logic       lock_clr = 1'b0;
   logic       cfg_we = 1'b0;
   logic [7:0] cfg_wdata = 8'h00;
   logic [7:0] cfg_rdata;
   logic       err_pulse;
   logic [7:0] status;
   logic       irq;
   logic       release_lines;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   scl_lowtime_guard u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .scl_in        (scl_in),
      .tick          (tick),
      .master_mode   (master_mode),
      .start_req     (start_req),
      .lock_clr      (lock_clr),
      .cfg_we        (cfg_we),
      .cfg_wdata     (cfg_wdata),
      .cfg_rdata     (cfg_rdata),
      .err_pulse     (err_pulse),
      .status        (status),
      .irq           (irq),
      .release_lines (release_lines)
   );

   // {cfg byte, tick count, expected error}
   localparam logic [16:0] VEC [8] = '{
      {8'h80, 8'd1,   1'b1},
      {8'h81, 8'd1,   1'b0},
      {8'h83, 8'd3,   1'b0},
      {8'h83, 8'd4,   1'b1},
      {8'h85, 8'd5,   1'b0},
      {8'h85, 8'd6,   1'b1},
      {8'hFF, 8'd127, 1'b0},
      {8'hFF, 8'd128, 1'b1}
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic write_cfg(input logic [7:0] v);
      cfg_wdata = v; cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         tick = 1'b1;
         @(negedge clk);
         tick = 1'b0;
      end
   endtask

   task automatic set_line(input logic v);
      scl_in = v;
      cyc(4);
   endtask

   task automatic clear_lock();
      lock_clr = 1'b1;
      @(negedge clk);
      lock_clr = 1'b0;
   endtask

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=expired expected=finished");
         summary();
      end
   end

   initial begin
      cyc(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 / R5: reset state
      chk("R1 cfg reset", cfg_rdata, 8'h00);
      chk("R5 idle status", status, 8'hF8);
      chk("R5 idle irq", {7'd0, irq}, 8'h00);
      chk("R5 idle release", {7'd0, release_lines}, 8'h00);
      write_cfg(8'hA7);
      chk("R1 cfg readback", cfg_rdata, 8'hA7);

      // R2: table walk, master mode falling edge
      master_mode = 1'b1;
      foreach (VEC[k]) begin
         write_cfg(VEC[k][16:9]);
         set_line(1'b0);
         ticks(int'(VEC[k][8:1]));
         chk("R2 irq after ticks", {7'd0, irq}, {7'd0, VEC[k][0]});
         chk("R2 status after ticks", status, VEC[k][0] ? 8'h78 : 8'hF8);
         set_line(1'b1);
         if (VEC[k][0]) clear_lock();
      end

      // R3 / R5: the pulse itself
      write_cfg(8'h82);
      set_line(1'b0);
      ticks(2);
      chk("R3 no pulse before expiry", {7'd0, err_pulse}, 8'h00);
      tick = 1'b1; @(negedge clk); tick = 1'b0;
      chk("R3 pulse high", {7'd0, err_pulse}, 8'h01);
      chk("R5 release on error", {7'd0, release_lines}, 8'h01);
      chk("R5 status on error", status, 8'h78);
      @(negedge clk);
      chk("R3 pulse one cycle", {7'd0, err_pulse}, 8'h00);

      // R8: lock persists through activity and reads
      set_line(1'b1);
      set_line(1'b0);
      ticks(5);
      chk("R8 irq held", {7'd0, irq}, 8'h01);
      chk("R8 status held", status, 8'h78);
      chk("R8 no second pulse", {7'd0, err_pulse}, 8'h00);
      set_line(1'b1);
      clear_lock();
      chk("R8 irq cleared", {7'd0, irq}, 8'h00);
      chk("R8 status cleared", status, 8'hF8);

      // R4: disabled guard stays silent
      write_cfg(8'h02);
      set_line(1'b0);
      ticks(10);
      chk("R4 disabled irq", {7'd0, irq}, 8'h00);
      set_line(1'b1);

      // R7: rise cancels, next fall reloads the full count
      write_cfg(8'h83);
      set_line(1'b0);
      ticks(2);
      set_line(1'b1);
      ticks(3);
      chk("R7 cancelled by rise", {7'd0, irq}, 8'h00);
      set_line(1'b0);
      ticks(3);
      chk("R7 reload no early error", {7'd0, irq}, 8'h00);
      ticks(1);
      chk("R7 reload error at N+1", {7'd0, irq}, 8'h01);
      set_line(1'b1);
      clear_lock();

      // R7: rise and final tick in the same cycle
      write_cfg(8'h82);
      set_line(1'b0);
      ticks(2);
      scl_in = 1'b1;
      cyc(2);            // rise now visible after two sync stages
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      cyc(1);
      chk("R7 same-cycle rise wins", {7'd0, irq}, 8'h00);
      ticks(4);
      chk("R7 no error after rise", {7'd0, irq}, 8'h00);

      // R9: not master, falling edge does not arm
      master_mode = 1'b0;
      write_cfg(8'h81);
      set_line(1'b0);
      ticks(6);
      chk("R9 slave fall ignored", {7'd0, irq}, 8'h00);

      // R6: start request with line held low
      start_req = 1'b1; @(negedge clk); start_req = 1'b0;
      ticks(1);
      chk("R6 no error at N", {7'd0, irq}, 8'h00);
      ticks(1);
      chk("R6 error at N+1", {7'd0, irq}, 8'h01);
      chk("R6 status", status, 8'h78);
      set_line(1'b1);
      clear_lock();

      // R10: start request with line high
      start_req = 1'b1; @(negedge clk); start_req = 1'b0;
      ticks(5);
      chk("R10 start with line high", {7'd0, irq}, 8'h00);

      done = 1'b1;
      summary();
   end
endmodule